// File: doc/BRIEF.md
# DSI Command Packet Composer

This block turns a display command into a complete DSI low-level packet, ready to be loaded into a transmit buffer. The command arrives one byte per handshake: the command byte first, then any parameters, with the final byte flagged. A 2-bit virtual channel is sampled with each byte, and the value sampled with the final byte is used. The packet type follows from the byte count. One or two bytes give a short packet. Three or more give a long packet, which carries a word count, the payload and a 16-bit checksum.

Once the command is complete, the block stops taking bytes. It writes the packet as little-endian 32-bit words, one word per cycle with an ascending index. After the last word it pulses a start strobe. In the same cycle as the strobe it presents the packet byte count minus one. Up to 64 payload bytes are held internally.

Top module: `dsi_cmd_packer`

## Requirements
- R1: A 1-byte command gives a 4-byte short packet: data identifier with data type 0x05, the command byte, 0x00, then the ECC byte.
- R2: A 2-byte command gives a 4-byte short packet: data identifier with data type 0x15, the command byte, the parameter, then the ECC byte.
- R3: A command of 3 or more bytes gives a long packet with data type 0x39. It contains the data identifier, the byte count low then high, the ECC byte, the payload bytes in arrival order, and the checksum low byte then high byte. The total length is the payload length plus 6.
- R4: The data identifier byte is the virtual channel in bits 7:6 and the data type in bits 5:0.
- R5: The ECC byte is the 6-bit DSI Hamming parity over the 24 header bits (first byte in bits 7:0), with bits 7:6 zero. Headers 05 11 00 give 0x36, 15 BC 4E gives 0x35, and 39 04 00 gives 0x2C.
- R6: Packet byte i is placed in word i/4 at bit 8*(i%4). Unused bytes of the last word are zero. Words appear with wr_valid_o high in consecutive cycles, at indices 0 upward.
- R7: In the cycle after the last word, start_o is high for exactly one cycle, and len_o in that cycle equals the total byte count minus 1.
- R8: The 64th accepted byte ends the command even when cmd_last_i is low, giving a 70-byte packet.
- R9: From the acceptance of the final byte until after the start pulse, cmd_ready_o is low and busy_o is high. In every other cycle cmd_ready_o is high and busy_o is low.
- R10: The checksum is a CRC-16 over the payload, using polynomial 0x1021 processed bit-reflected (0x8408), seed 0xFFFF and no final inversion. Payload B9 F1 12 83 gives the bytes 84 5D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vc_i | input | 2 | Virtual channel, sampled with each accepted byte |
| cmd_valid_i | input | 1 | Command byte valid |
| cmd_data_i | input | 8 | Command or parameter byte |
| cmd_last_i | input | 1 | Marks the final byte of a command |
| cmd_ready_o | output | 1 | Byte accepted when high together with cmd_valid_i |
| busy_o | output | 1 | A packet is being composed or emitted |
| wr_valid_o | output | 1 | Packet word valid |
| wr_idx_o | output | 5 | Word index within the packet |
| wr_data_o | output | 32 | Packet word, little-endian |
| len_o | output | 7 | Total packet bytes minus one, valid while start_o is high |
| start_o | output | 1 | One-cycle launch strobe |

## Verification
The assertions take for granted that commands are delivered whole, and that a source does not wait for cmd_ready_o before presenting the next byte. They also assume the virtual channel is steady while a command is in flight. The bench drives each byte at a falling edge, holds it until ready is seen high, and keeps vc_i constant for the whole command. Random lengths from 1 to 64 bytes, random gaps between bytes, and directed cases (the stated header and checksum vectors, every virtual channel, and a 64-byte command with no last flag) cover the short, long and overflow paths.

// File: rtl/dsi_pkt_pkg.sv
package dsi_pkt_pkg;
  localparam logic [5:0] DT_SHORT0 = 6'h05;
  localparam logic [5:0] DT_SHORT1 = 6'h15;
  localparam logic [5:0] DT_LONG   = 6'h39;

  typedef enum logic [1:0] {ST_IDLE, ST_EMIT, ST_KICK} pk_state_e;
endpackage

// File: rtl/dsi_ecc_gen.sv
module dsi_ecc_gen (
  input  logic [23:0] hdr_i,
  output logic [7:0]  ecc_o
);
  logic [23:0] d;
  assign d = hdr_i;

  always_comb begin
    ecc_o    = '0;
    ecc_o[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
    ecc_o[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
    ecc_o[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
    ecc_o[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
    ecc_o[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
    ecc_o[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
  end
endmodule

// File: rtl/dsi_crc_byte.sv
module dsi_crc_byte #(
  parameter logic [15:0] POLY_REFL = 16'h8408
) (
  input  logic [15:0] crc_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  always_comb begin
    logic [15:0] c;
    logic        fb;
    c = crc_i;
    for (int b = 0; b < 8; b++) begin
      fb = c[0] ^ data_i[b];
      c  = c >> 1;
      if (fb) c = c ^ POLY_REFL;
    end
    crc_o = c;
  end
endmodule

// File: rtl/dsi_cmd_packer.sv
module dsi_cmd_packer
  import dsi_pkt_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  localparam int CNT_W  = $clog2(MAX_BYTES + 1),
  localparam int BUF_AW = $clog2(MAX_BYTES),
  localparam int TOT_W  = $clog2(MAX_BYTES + 10),
  localparam int WIDX_W = $clog2((MAX_BYTES + 9) / 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        vc_i,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_data_i,
  input  logic              cmd_last_i,
  output logic              cmd_ready_o,
  output logic              busy_o,
  output logic              wr_valid_o,
  output logic [WIDX_W-1:0] wr_idx_o,
  output logic [31:0]       wr_data_o,
  output logic [TOT_W-1:0]  len_o,
  output logic              start_o
);
  pk_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [15:0]       crc_q, crc_nxt;
  logic [1:0]        vc_q;
  logic [WIDX_W-1:0] widx_q;
  logic [7:0]        buf_q [MAX_BYTES];

  logic              accept, done_byte, is_long;
  logic [TOT_W-1:0]  total;
  logic [WIDX_W-1:0] last_widx;
  logic [5:0]        dtype;
  logic [7:0]        di, h1, h2, ecc;
  logic [15:0]       wc;

  assign accept    = cmd_valid_i && (state_q == ST_IDLE);
  assign done_byte = accept && (cmd_last_i || cnt_q == CNT_W'(MAX_BYTES - 1));

  dsi_crc_byte i_crc (.crc_i(crc_q), .data_i(cmd_data_i), .crc_o(crc_nxt));

  always_ff @(posedge clk_i) begin
    if (accept) buf_q[BUF_AW'(cnt_q)] <= cmd_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      crc_q   <= 16'hFFFF;
      vc_q    <= '0;
      widx_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cnt_q <= cnt_q + 1'b1;
          crc_q <= crc_nxt;
          vc_q  <= vc_i;
          if (done_byte) begin
            state_q <= ST_EMIT;
            widx_q  <= '0;
          end
        end
        ST_EMIT: begin
          widx_q <= widx_q + 1'b1;
          if (widx_q == last_widx) state_q <= ST_KICK;
        end
        ST_KICK: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
          crc_q   <= 16'hFFFF;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // header fields
  always_comb begin
    is_long   = cnt_q > CNT_W'(2);
    total     = is_long ? TOT_W'(cnt_q) + TOT_W'(6) : TOT_W'(4);
    last_widx = WIDX_W'((int'(total) + 3) / 4 - 1);
    dtype     = is_long ? DT_LONG : (cnt_q == CNT_W'(2) ? DT_SHORT1 : DT_SHORT0);
    di        = {vc_q, dtype};
    wc        = 16'(cnt_q);
    h1        = is_long ? wc[7:0]  : buf_q[0];
    h2        = is_long ? wc[15:8] : (cnt_q == CNT_W'(2) ? buf_q[1] : 8'h00);
  end

  dsi_ecc_gen i_ecc (.hdr_i({h2, h1, di}), .ecc_o(ecc));

  logic [7:0] lane_byte [4];
  for (genvar l = 0; l < 4; l++) begin : g_lane
    always_comb begin
      int k, n;
      k = int'(widx_q) * 4 + l;
      n = int'(cnt_q);
      if      (k == 0) lane_byte[l] = di;
      else if (k == 1) lane_byte[l] = h1;
      else if (k == 2) lane_byte[l] = h2;
      else if (k == 3) lane_byte[l] = ecc;
      else if (!is_long)   lane_byte[l] = 8'h00;
      else if (k < n + 4)  lane_byte[l] = buf_q[BUF_AW'(k - 4)];
      else if (k == n + 4) lane_byte[l] = crc_q[7:0];
      else if (k == n + 5) lane_byte[l] = crc_q[15:8];
      else                 lane_byte[l] = 8'h00;
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign wr_valid_o  = (state_q == ST_EMIT);
  assign wr_idx_o    = widx_q;
  assign wr_data_o   = {lane_byte[3], lane_byte[2], lane_byte[1], lane_byte[0]};
  assign len_o       = total - 1'b1;
  assign start_o     = (state_q == ST_KICK);

  p_start_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  p_start_after_words_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(wr_valid_o));
  p_word_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && $past(wr_valid_o)) |-> wr_idx_o == WIDX_W'($past(wr_idx_o) + 1'b1));
  p_first_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_valid_o) |-> wr_idx_o == '0);
  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_BYTES));
  p_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o || start_o) |-> (!cmd_ready_o && busy_o));
  p_len_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (len_o == TOT_W'(3) || (len_o >= TOT_W'(8) && len_o <= TOT_W'(MAX_BYTES + 5))));
  p_ecc_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_idx_o == '0) |-> wr_data_o[31:30] == 2'b00);
endmodule

// File: tb/test_dsi_cmd_packer.sv
module test_dsi_cmd_packer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  vc_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic [7:0]  cmd_data_i = '0;
  logic        cmd_last_i = 1'b0;
  logic        cmd_ready_o, busy_o, wr_valid_o, start_o;
  logic [4:0]  wr_idx_o;
  logic [31:0] wr_data_o;
  logic [6:0]  len_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  pl    [64];
  logic [7:0]  exp_b [80];
  int          exp_total;
  logic [31:0] cap_w [32];

  always #4 clk_i = ~clk_i;

  dsi_cmd_packer i_dsi_cmd_packer (
    .clk_i(clk_i), .rst_ni(rst_ni), .vc_i(vc_i), .cmd_valid_i(cmd_valid_i),
    .cmd_data_i(cmd_data_i), .cmd_last_i(cmd_last_i), .cmd_ready_o(cmd_ready_o),
    .busy_o(busy_o), .wr_valid_o(wr_valid_o), .wr_idx_o(wr_idx_o),
    .wr_data_o(wr_data_o), .len_o(len_o), .start_o(start_o));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_ecc(input logic [23:0] h);
    logic [23:0] m [6];
    logic [7:0]  e;
    m[0] = 24'hF12CB7; m[1] = 24'hF2555B; m[2] = 24'h749A6D;
    m[3] = 24'hB8E38E; m[4] = 24'hDF03F0; m[5] = 24'hEFFC00;
    e = '0;
    for (int p = 0; p < 6; p++) e[p] = ^(h & m[p]);
    return e;
  endfunction

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ pl[i][b]) c = (c >> 1) ^ 16'h8408;
        else                 c = c >> 1;
      end
    return c;
  endfunction

  task automatic build(input int n, input logic [1:0] vc);
    logic [7:0]  di;
    logic [15:0] crc;
    for (int i = 0; i < 80; i++) exp_b[i] = 8'h00;
    if (n == 1) begin
      di = {vc, 6'h05};
      exp_b[0] = di; exp_b[1] = pl[0]; exp_b[2] = 8'h00;
      exp_total = 4;
    end else if (n == 2) begin
      di = {vc, 6'h15};
      exp_b[0] = di; exp_b[1] = pl[0]; exp_b[2] = pl[1];
      exp_total = 4;
    end else begin
      di = {vc, 6'h39};
      exp_b[0] = di; exp_b[1] = 8'(n); exp_b[2] = 8'(n >> 8);
      for (int i = 0; i < n; i++) exp_b[4 + i] = pl[i];
      crc = ref_crc(n);
      exp_b[n + 4] = crc[7:0];
      exp_b[n + 5] = crc[15:8];
      exp_total = n + 6;
    end
    exp_b[3] = ref_ecc({exp_b[2], exp_b[1], exp_b[0]});
  endtask

  // send n bytes; with_last=0 leaves cmd_last_i low throughout
  task automatic run_cmd(input int n, input logic [1:0] vc, input bit with_last, input bit gaps);
    int    n_eff, words, got;
    bit    seen_start;
    string tag;
    n_eff = (n > 64) ? 64 : n;
    build(n_eff, vc);
    tag = (n_eff == 1) ? "R1" : (n_eff == 2) ? "R2" : (with_last ? "R3" : "R8");
    words = (exp_total + 3) / 4;
    @(negedge clk_i);
    for (int i = 0; i < n_eff; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        cmd_valid_i = 1'b0;
        @(negedge clk_i);
      end
      cmd_valid_i = 1'b1;
      cmd_data_i  = pl[i];
      cmd_last_i  = with_last && (i == n_eff - 1);
      vc_i        = vc;
      while (!cmd_ready_o) @(negedge clk_i);
      @(negedge clk_i);
    end
    cmd_valid_i = 1'b0;
    cmd_last_i  = 1'b0;
    got = 0;
    seen_start = 1'b0;
    for (int c = 0; c < 40 && !seen_start; c++) begin
      if (wr_valid_o) begin
        chk(!cmd_ready_o && busy_o, "R9 blocked while emitting", {30'd0, cmd_ready_o, busy_o}, 32'h1);
        chk(int'(wr_idx_o) == got, "R6 word index", 32'(wr_idx_o), 32'(got));
        chk(wr_data_o == {exp_b[got*4+3], exp_b[got*4+2], exp_b[got*4+1], exp_b[got*4]},
            {tag, " R6 word"}, wr_data_o,
            {exp_b[got*4+3], exp_b[got*4+2], exp_b[got*4+1], exp_b[got*4]});
        cap_w[got] = wr_data_o;
        got++;
      end
      if (start_o) begin
        seen_start = 1'b1;
        chk(int'(len_o) == exp_total - 1, {tag, " R7 length"}, 32'(len_o), 32'(exp_total - 1));
        chk(!cmd_ready_o && busy_o, "R9 blocked at start", {30'd0, cmd_ready_o, busy_o}, 32'h1);
      end else begin
        @(negedge clk_i);
      end
    end
    chk(seen_start, "R7 start seen", 32'(seen_start), 32'h1);
    chk(got == words, "R6 word count", 32'(got), 32'(words));
    @(negedge clk_i);
    chk(!start_o && cmd_ready_o && !busy_o, "R7 R9 one-cycle start then idle",
        {29'd0, start_o, cmd_ready_o, busy_o}, 32'h2);
  endtask

  initial begin
    #1_200_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk_i);
    chk(cmd_ready_o && !busy_o && !wr_valid_o && !start_o, "R9 reset state",
        {28'd0, cmd_ready_o, busy_o, wr_valid_o, start_o}, 32'h8);
    rst_ni = 1'b1;
    @(negedge clk_i);

    pl[0] = 8'h11;
    run_cmd(1, 2'd0, 1'b1, 1'b0);
    chk(cap_w[0] == 32'h36001105, "R1 R5 ecc 05 11 00", cap_w[0], 32'h36001105);

    pl[0] = 8'hBC; pl[1] = 8'h4E;
    run_cmd(2, 2'd0, 1'b1, 1'b0);
    chk(cap_w[0] == 32'h354EBC15, "R2 R5 ecc 15 BC 4E", cap_w[0], 32'h354EBC15);

    pl[0] = 8'hB9; pl[1] = 8'hF1; pl[2] = 8'h12; pl[3] = 8'h83;
    run_cmd(4, 2'd0, 1'b1, 1'b0);
    chk(cap_w[0] == 32'h2C000439, "R3 R5 ecc 39 04 00", cap_w[0], 32'h2C000439);
    chk(cap_w[2] == 32'h00005D84, "R10 checksum 84 5D", cap_w[2], 32'h00005D84);

    pl[0] = 8'h29;
    run_cmd(1, 2'd3, 1'b1, 1'b0);
    chk(cap_w[0][7:0] == 8'hC5, "R4 channel 3 identifier", 32'(cap_w[0][7:0]), 32'hC5);

    pl[0] = 8'hAA; pl[1] = 8'h55; pl[2] = 8'h0F;
    run_cmd(3, 2'd1, 1'b1, 1'b1);
    chk(cap_w[0][7:0] == 8'h79, "R4 channel 1 long identifier", 32'(cap_w[0][7:0]), 32'h79);

    for (int i = 0; i < 64; i++) pl[i] = 8'($urandom);
    run_cmd(64, 2'd2, 1'b1, 1'b0);
    for (int i = 0; i < 64; i++) pl[i] = 8'($urandom);
    run_cmd(64, 2'd1, 1'b0, 1'b1);   // R8: no last flag

    for (int t = 0; t < 40; t++) begin
      n = (t % 5 == 0) ? 1 + int'($urandom % 2) : 1 + int'($urandom % 64);
      for (int i = 0; i < 64; i++) pl[i] = 8'($urandom);
      run_cmd(n, 2'($urandom), 1'b1, 1'b1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule